// File: doc/BRIEF.md
# Oversampled Manchester Bit-Clock Recovery

This block takes a Manchester-coded serial line and recovers the bit timing and the data from it. A fast local clock runs at a fixed multiple (8 or 32, set by parameter) of the nominal bit rate. On every local clock the line is sampled into a shift register exactly one bit period long. A down-counter marks the regenerated bit boundaries. At each boundary the register is searched for the signal edge closest to its middle, and the counter's next reload is moved by one sample if that edge is off centre.

Each boundary produces a one-cycle strobe together with the decoded bit. A lock flag reports whether the edges have stayed close to centre. Once the loop has settled, a train of alternating bits holds the mid-bit edge in the middle of the window. From then on only single-sample nudges are needed to follow a transmitter whose rate differs slightly from the local one.

Top module: `mclk_recovery`

## Requirements
- R1: While `rst` is high, `bit_stb` and `locked` are 0, the sample window holds all zeros and the boundary counter is loaded with OSR-1. The first boundary evaluation happens OSR-1 cycles after reset is released, and its strobe is seen one cycle later.
- R2: `bit_stb` is high for exactly one cycle per regenerated bit period, and the period between strobes is OSR-1, OSR or OSR+1 cycles.
- R3: The window holds the last OSR samples, with index 0 the newest. An edge at position k (k from 1 to OSR-1) means sample k differs from sample k-1. The edge used is the one with the smallest |k-OSR/2|, limited to |k-OSR/2| <= OSR/4-1. On a tie the older edge (larger k) wins.
- R4: A selected edge at k > OSR/2 shortens the next period to OSR-1 cycles. An edge at k < OSR/2 lengthens it to OSR+1. An edge exactly at OSR/2 leaves it at OSR.
- R5: When no edge lies inside the search range, no correction is made and the next period is OSR cycles.
- R6: The decoded bit is the sample just after the selected edge (sample k-1). Because a 1 is sent as a low half followed by a high half, a rising edge at centre decodes as 1 and a falling edge as 0. With no edge, sample OSR/2-1 is used. The bit is presented on `bit_val` in the strobe cycle.
- R7: `locked` rises after 8 consecutive evaluations whose selected edge is within 1 sample of centre.
- R8: `locked` falls after 4 consecutive evaluations that have either no edge or an edge more than 3 samples from centre. An evaluation that is neither near nor far restarts both runs.
- R9: `locked` changes only in a cycle where `bit_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, OSR times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Manchester-coded serial input |
| bit_stb | output | 1 | One-cycle strobe per recovered bit |
| bit_val | output | 1 | Decoded bit, valid when `bit_stb` is high |
| locked | output | 1 | Loop is tracking the mid-bit edge |

## Verification
The evaluation happens in the cycle where the boundary counter reads zero. It looks at the window as it stood before that clock edge. The strobe, decoded bit and lock flag are all registered at that edge, so they are due exactly one cycle after the counter reaches zero. The bench reference model updates its sample queue and counter at each rising edge, in the same order as the hardware. The bench drives the line at falling edges and compares the outputs at falling edges, so every comparison falls half a cycle after the edge that produced the result. The period checks measure the distance between strobes in whole cycles at the same falling-edge sampling point.

// File: rtl/mclk_pkg.sv
package mclk_pkg;

   // Reload choice for the next regenerated bit period
   typedef enum logic [1:0] {
      STEP_HOLD  = 2'd0,
      STEP_EARLY = 2'd1,
      STEP_LATE  = 2'd2
   } step_e;

endpackage

// File: rtl/mclk_edge_finder.sv
// Searches a one-bit-long sample window for the edge nearest its middle.
module mclk_edge_finder #(
   parameter int OSR = 32
) (
   input  logic [OSR-1:0]                      win,
   output logic                                found,
   output logic signed [$clog2(OSR/2):0]       offset,
   output logic                                data
);
   localparam int HALF  = OSR / 2;
   localparam int LIMIT = OSR / 4 - 1;
   localparam int OFS_W = $clog2(HALF) + 1;

   logic [OSR-1:0] edge_at;

   assign edge_at[0] = 1'b0;

   genvar g;
   generate
      for (g = 1; g < OSR; g++) begin : g_edge
         assign edge_at[g] = win[g] ^ win[g-1];
      end
   endgenerate

   // Walk outward-in so the nearest edge overwrites farther ones; the
   // older side is tested last at each distance so it wins a tie (R3).
   always_comb begin
      found  = 1'b0;
      offset = '0;
      data   = win[HALF-1];
      for (int r = LIMIT; r >= 0; r--) begin
         if (edge_at[HALF-r]) begin
            found  = 1'b1;
            offset = -(OFS_W'(r));
            data   = win[HALF-r-1];
         end
         if (edge_at[HALF+r]) begin
            found  = 1'b1;
            offset = OFS_W'(r);
            data   = win[HALF+r-1];
         end
      end
   end

endmodule

// File: rtl/mclk_phase_ctr.sv
// Regenerated bit-period counter with a one-sample reload nudge.
module mclk_phase_ctr
   import mclk_pkg::*;
#(
   parameter int OSR = 32
) (
   input  logic  clk,
   input  logic  rst,
   input  step_e step,
   output logic  boundary
);
   localparam int CW = $clog2(OSR + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] reload;

   assign boundary = (cnt == '0);

   always_comb begin
      case (step)
         STEP_EARLY: reload = CW'(OSR - 2);
         STEP_LATE:  reload = CW'(OSR);
         default:    reload = CW'(OSR - 1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= CW'(OSR - 1);
      else if (boundary)
         cnt <= reload;
      else
         cnt <= cnt - CW'(1);
   end

endmodule

// File: rtl/mclk_lock_trk.sv
// Run-length lock qualifier driven by the per-bit edge offset.
module mclk_lock_trk #(
   parameter int OFS_W      = 5,
   parameter int LOCK_RUN   = 8,
   parameter int UNLOCK_RUN = 4,
   parameter int NEAR       = 1,
   parameter int FAR        = 3
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    eval,
   input  logic                    found,
   input  logic signed [OFS_W-1:0] offset,
   output logic                    locked
);
   localparam int GW = $clog2(LOCK_RUN + 1);
   localparam int BW = $clog2(UNLOCK_RUN + 1);

   logic [GW-1:0]    good_run;
   logic [BW-1:0]    bad_run;
   logic [OFS_W-1:0] mag;
   logic             is_good;
   logic             is_bad;

   assign mag     = offset[OFS_W-1] ? OFS_W'(-offset) : OFS_W'(offset);
   assign is_good = found && (int'(mag) <= NEAR);
   assign is_bad  = !found || (int'(mag) > FAR);

   always_ff @(posedge clk) begin
      if (rst) begin
         good_run <= '0;
         bad_run  <= '0;
         locked   <= 1'b0;
      end else if (eval) begin
         if (is_good) begin
            bad_run <= '0;
            if (good_run != GW'(LOCK_RUN))
               good_run <= good_run + GW'(1);
            if (good_run >= GW'(LOCK_RUN - 1))
               locked <= 1'b1;
         end else if (is_bad) begin
            good_run <= '0;
            if (bad_run != BW'(UNLOCK_RUN))
               bad_run <= bad_run + BW'(1);
            if (bad_run >= BW'(UNLOCK_RUN - 1))
               locked <= 1'b0;
         end else begin
            good_run <= '0;
            bad_run  <= '0;
         end
      end
   end

endmodule

// File: rtl/mclk_recovery.sv
module mclk_recovery
   import mclk_pkg::*;
#(
   parameter int OSR        = 32,
   parameter int LOCK_RUN   = 8,
   parameter int UNLOCK_RUN = 4,
   parameter int NEAR       = 1,
   parameter int FAR        = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic line_in,
   output logic bit_stb,
   output logic bit_val,
   output logic locked
);
   localparam int HALF  = OSR / 2;
   localparam int OFS_W = $clog2(HALF) + 1;

   generate
      if (!(OSR == 8 || OSR == 32)) begin : g_bad_osr
         $error("mclk_recovery: OSR must be 8 or 32");
      end
      if (LOCK_RUN < 1 || UNLOCK_RUN < 1) begin : g_bad_run
         $error("mclk_recovery: run lengths must be at least 1");
      end
      if (NEAR > FAR) begin : g_bad_band
         $error("mclk_recovery: NEAR must not exceed FAR");
      end
   endgenerate

   logic [OSR-1:0]          window;
   logic                    boundary;
   logic                    edge_found;
   logic signed [OFS_W-1:0] edge_ofs;
   logic                    edge_data;
   step_e                   step;

   // Newest sample enters at index 0
   always_ff @(posedge clk) begin
      if (rst)
         window <= '0;
      else
         window <= {window[OSR-2:0], line_in};
   end

   mclk_edge_finder #(.OSR(OSR)) u_find (
      .win    (window),
      .found  (edge_found),
      .offset (edge_ofs),
      .data   (edge_data)
   );

   // Older-than-centre edge: boundary is late, pull it in (R4)
   always_comb begin
      step = STEP_HOLD;
      if (edge_found && edge_ofs != '0)
         step = edge_ofs[OFS_W-1] ? STEP_LATE : STEP_EARLY;
   end

   mclk_phase_ctr #(.OSR(OSR)) u_phase (
      .clk      (clk),
      .rst      (rst),
      .step     (step),
      .boundary (boundary)
   );

   mclk_lock_trk #(
      .OFS_W      (OFS_W),
      .LOCK_RUN   (LOCK_RUN),
      .UNLOCK_RUN (UNLOCK_RUN),
      .NEAR       (NEAR),
      .FAR        (FAR)
   ) u_lock (
      .clk    (clk),
      .rst    (rst),
      .eval   (boundary),
      .found  (edge_found),
      .offset (edge_ofs),
      .locked (locked)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_stb <= 1'b0;
         bit_val <= 1'b0;
      end else begin
         bit_stb <= boundary;
         if (boundary)
            bit_val <= edge_data;
      end
   end

endmodule

// File: rtl/mclk_recovery_chk.sv
module mclk_recovery_chk #(
   parameter int OSR = 32
) (
   input logic clk,
   input logic rst,
   input logic bit_stb,
   input logic locked
);
   int   gap;
   logic seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap  <= 0;
         seen <= 1'b0;
      end else if (bit_stb) begin
         gap  <= 1;
         seen <= 1'b1;
      end else begin
         gap  <= gap + 1;
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (!bit_stb && !locked));

   assert_stb_single_R2: assert property (@(posedge clk) disable iff (rst)
      bit_stb |=> !bit_stb);

   assert_stb_period_R2: assert property (@(posedge clk) disable iff (rst)
      (seen && bit_stb) |-> (gap >= OSR - 1 && gap <= OSR + 1));

   assert_lock_rise_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> bit_stb);

   assert_lock_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !bit_stb |-> $stable(locked));

endmodule

bind mclk_recovery mclk_recovery_chk #(.OSR(OSR)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .bit_stb (bit_stb),
   .locked  (locked)
);

// File: tb/mclk_recovery_tb.sv
module mclk_recovery_tb;
   localparam int CLK_PERIOD = 10;
   localparam int OSR   = 32;
   localparam int HALF  = OSR / 2;
   localparam int LIMIT = OSR / 4 - 1;
   localparam int WATCHDOG = 100000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic line_in = 1'b0;
   logic bit_stb, bit_val, locked;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mclk_recovery #(.OSR(OSR)) u_dut (
      .clk     (clk),
      .rst     (rst),
      .line_in (line_in),
      .bit_stb (bit_stb),
      .bit_val (bit_val),
      .locked  (locked)
   );

   // ---------------- reference model ----------------
   bit q[$];
   int m_cnt;
   bit m_stb, m_val, m_lock;
   int m_good, m_bad;

   always @(posedge clk) begin
      if (rst) begin
         q.delete();
         for (int i = 0; i < OSR; i++) q.push_back(1'b0);
         m_cnt = OSR - 1; m_stb = 0; m_val = 0; m_lock = 0;
         m_good = 0; m_bad = 0;
      end else begin
         m_stb = (m_cnt == 0);
         if (m_cnt == 0) begin
            int d; bit f; bit v;
            f = 0; d = 0; v = q[HALF-1];
            for (int r = 0; r <= LIMIT && !f; r++) begin
               if (q[HALF+r] != q[HALF+r-1]) begin
                  f = 1; d = r; v = q[HALF+r-1];
               end else if (q[HALF-r] != q[HALF-r-1]) begin
                  f = 1; d = -r; v = q[HALF-r-1];
               end
            end
            m_val = v;
            if (f && d > 0) m_cnt = OSR - 2;
            else if (f && d < 0) m_cnt = OSR;
            else m_cnt = OSR - 1;
            if (f && (d <= 1 && d >= -1)) begin
               m_bad = 0; m_good++;
               if (m_good >= 8) m_lock = 1;
            end else if (!f || d > 3 || d < -3) begin
               m_good = 0; m_bad++;
               if (m_bad >= 4) m_lock = 0;
            end else begin
               m_good = 0; m_bad = 0;
            end
         end else begin
            m_cnt--;
         end
         q.push_front(line_in);
         void'(q.pop_back());
      end
   end

   // ---------------- checking ----------------
   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   int since_stb = 0;
   int adj_gaps = 0;
   bit gap_exact = 0;
   bit val_en = 0;
   bit val_exp = 0;

   always @(negedge clk) begin
      cycles++;
      if (!rst && !done) begin
         check(bit_stb == m_stb, "R2 strobe timing", bit_stb, m_stb);
         check(locked == m_lock, "R7 R8 lock flag", locked, m_lock);
         if (m_stb)
            check(bit_val == m_val, "R6 decoded bit", bit_val, m_val);
         since_stb++;
         if (bit_stb) begin
            if (since_stb != OSR) adj_gaps++;
            if (gap_exact)
               check(since_stb == OSR, "R4 R5 period without correction", since_stb, OSR);
            if (val_en)
               check(bit_val == val_exp, "R3 R6 data pattern", bit_val, val_exp);
            since_stb = 0;
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic put(input bit v, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         line_in = v;
      end
   endtask

   // 1 is sent as low half then high half
   task automatic send_bit(input bit b, input int stretch);
      put(~b, HALF);
      put(b, HALF + stretch);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(bit_stb == 1'b0, "R1 reset strobe", bit_stb, 0);
      check(locked == 1'b0, "R1 reset lock", locked, 0);
      rst = 1'b0;
      // R1: first strobe lands OSR cycles after release
      repeat (OSR - 1) @(negedge clk);
      check(bit_stb == 1'b0, "R1 no early strobe", bit_stb, 0);
      @(negedge clk);
      check(bit_stb == 1'b1, "R1 first strobe", bit_stb, 1);
      put(1'b0, 5);
      since_stb = 0;
      adj_gaps = 0;
      // alternating acquisition train
      for (int i = 0; i < 40; i++) send_bit(i[0] ? 1'b0 : 1'b1, 0);
      check(adj_gaps > 0, "R4 correction applied while acquiring", adj_gaps, 1);
      check(locked == 1'b1, "R7 locked after training", locked, 1);
      // steady ones: no correction, data 1
      send_bit(1'b1, 0); send_bit(1'b1, 0);
      gap_exact = 1; val_en = 1; val_exp = 1'b1;
      for (int i = 0; i < 12; i++) send_bit(1'b1, 0);
      val_en = 0;
      send_bit(1'b0, 0); send_bit(1'b0, 0);
      val_en = 1; val_exp = 1'b0;
      for (int i = 0; i < 12; i++) send_bit(1'b0, 0);
      val_en = 0; gap_exact = 0;
      check(locked == 1'b1, "R7 lock held on steady data", locked, 1);
      // slow transmitter: one extra sample each bit
      adj_gaps = 0;
      for (int i = 0; i < 30; i++) send_bit(i[1], 1);
      check(adj_gaps > 0, "R4 tracking a slow source", adj_gaps, 1);
      check(locked == 1'b1, "R7 lock kept while tracking", locked, 1);
      // idle line: no edges, lock drops, no corrections
      put(1'b0, 3 * OSR);
      gap_exact = 1;
      put(1'b0, 4 * OSR);
      gap_exact = 0;
      check(locked == 1'b0, "R8 lock lost on idle line", locked, 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cycles > WATCHDOG);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule